// File: doc/BRIEF.md
# Pixel Clock Loss Monitor with Sleep Control

This block watches an incoming pixel clock from a free-running reference clock. It counts pixel-clock edges over a fixed reference window. When a window holds fewer edges than a clock of about 1 MHz would give, the pixel clock is reported as absent. If sleep is enabled, the block then raises a sleep request so that the surrounding logic can drop into a low-power state. With sleep disabled, the loss is only flagged.

While asleep, the block keeps measuring. It leaves sleep only after two consecutive windows show a healthy clock, which keeps it from chattering near the threshold. It then raises a relock request for a fixed number of reference cycles, during which the downstream PLL is expected to lock, and returns to normal operation.

A small configuration register bank sits beside the monitor on the reference clock. It has no reset at all, so its contents survive clock loss, sleep and a block reset alike.

Top module: `pclk_loss_monitor`

## Requirements
- R1: At the end of every window of WIN_LEN reference cycles, `clk_present` becomes 1 if at least MIN_EDGES = WIN_LEN*LOSS_KHZ/REF_KHZ pixel rising edges were counted in that window, and 0 otherwise. It changes at no other time.
- R2: With `sleep_en`=1, a window that reports loss while the block is active raises `sleep_req` on the same clock edge that clears `clk_present`.
- R3: With `sleep_en`=0, loss clears `clk_present` but `sleep_req` stays 0.
- R4: Sleep is left only after two consecutive good windows. A single good window followed by a bad one keeps `sleep_req` at 1.
- R5: On leaving sleep, `relock_req` is 1 for exactly RELOCK_LEN reference cycles, after which both requests are 0.
- R6: If a window reports loss with `sleep_en`=1 in the same cycle that the relock period ends, the block goes back to sleep and does not return to active.
- R7: After reset the block is active: `clk_present`=1, `sleep_req`=0 and `relock_req`=0.
- R8: A write with `cfg_we`=1 stores `cfg_wdata` at `cfg_addr` on the reference clock edge, and `cfg_rdata` shows the word at `cfg_addr` without delay. The stored contents survive sleep and reset.
- R9: `sleep_req` and `relock_req` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Monitored pixel clock |
| sleep_en | input | 1 | Allows sleep entry on loss |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | CFG_DW | Configuration write data |
| cfg_rdata | output | CFG_DW | Configuration read data at cfg_addr |
| clk_present | output | 1 | Pixel clock judged present in the last window |
| sleep_req | output | 1 | Low-power sleep request |
| relock_req | output | 1 | Relock period in progress |

## Verification
Two events can land in the same cycle: the end of the relock countdown and a window verdict of loss. With the default parameters the relock period equals the window length, so the countdown always ends on a window boundary. The bench stops the pixel clock as soon as `relock_req` rises, which makes the next window fail in exactly the cycle the countdown expires. It then expects the outputs to move straight from relock to sleep with `clk_present` low, with no active state in between. A scoreboard of expected output transitions judges this, along with every other scenario.

// File: rtl/pclm_pkg.sv
package pclm_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_RELOCK = 2'd2
  } pclm_state_e;
endpackage

// File: rtl/pclm_edge_sync.sv
// Toggle flop in the pixel domain, synchronized into the reference domain;
// each observed toggle is one pixel rising edge.
module pclm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic pix_clk,
  input  logic pix_rst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  output logic pix_edge
);
  logic                 tog_q;
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n) tog_q <= 1'b0;
    else            tog_q <= ~tog_q;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-1:0], tog_q};
  end

  assign pix_edge = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/pclm_window.sv
module pclm_window #(
  parameter int WIN_LEN   = 1000,
  parameter int MIN_EDGES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_edge,
  output logic win_done,
  output logic win_ok,
  output logic present
);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int EDGE_W = $clog2(MIN_EDGES + 1);

  logic [WIN_W-1:0]  win_q, win_n;
  logic [EDGE_W-1:0] edg_q, edg_n;
  logic              pres_q, pres_n;

  assign win_done = (win_q == WIN_W'(WIN_LEN - 1));
  assign win_ok   = (edg_q >= EDGE_W'(MIN_EDGES));

  always_comb begin
    win_n  = win_done ? '0 : win_q + 1'b1;
    edg_n  = edg_q;
    pres_n = pres_q;
    if (win_done) begin
      edg_n  = '0;
      pres_n = win_ok;
    end else if (pix_edge && !win_ok) begin
      edg_n = edg_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      edg_q  <= '0;
      pres_q <= 1'b1;
    end else begin
      win_q  <= win_n;
      edg_q  <= edg_n;
      pres_q <= pres_n;
    end
  end

  assign present = pres_q;

  AST_WIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WIN_W'(WIN_LEN - 1)); // R1
  AST_EDGE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    edg_q <= EDGE_W'(MIN_EDGES)); // R1
endmodule

// File: rtl/pclm_fsm.sv
module pclm_fsm
  import pclm_pkg::*;
#(
  parameter int RELOCK_LEN = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_done,
  input  logic win_ok,
  input  logic sleep_en,
  output logic sleep_req,
  output logic relock_req
);
  localparam int RL_W = (RELOCK_LEN > 1) ? $clog2(RELOCK_LEN) : 1;

  pclm_state_e      st_q, st_n;
  logic [RL_W-1:0]  rl_q, rl_n;
  logic             streak_q, streak_n;
  logic             loss_hit, rl_done;

  assign loss_hit = win_done && !win_ok && sleep_en;
  assign rl_done  = (rl_q == '0);

  always_comb begin
    st_n     = st_q;
    rl_n     = rl_q;
    streak_n = streak_q;
    case (st_q)
      ST_ACTIVE: begin
        streak_n = 1'b0;
        if (loss_hit) st_n = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (win_done) begin
          if (!win_ok) begin
            streak_n = 1'b0;
          end else if (streak_q) begin
            st_n     = ST_RELOCK;
            rl_n     = RL_W'(RELOCK_LEN - 1);
            streak_n = 1'b0;
          end else begin
            streak_n = 1'b1;
          end
        end
      end
      ST_RELOCK: begin
        if (loss_hit)     st_n = ST_SLEEP;   // loss outranks expiry
        else if (rl_done) st_n = ST_ACTIVE;
        else              rl_n = rl_q - 1'b1;
      end
      default: st_n = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_ACTIVE;
      rl_q     <= '0;
      streak_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      rl_q     <= rl_n;
      streak_q <= streak_n;
    end
  end

  assign sleep_req  = (st_q == ST_SLEEP);
  assign relock_req = (st_q == ST_RELOCK);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_req && relock_req)); // R9
  AST_SLEEP_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> $past(sleep_en)); // R3
  AST_WAKE_GOES_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_req) |-> relock_req); // R5
  AST_LOSS_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (relock_req && win_done && !win_ok && sleep_en) |=> sleep_req); // R6
endmodule

// File: rtl/pclm_cfg_bank.sv
// Deliberately unreset storage: contents persist through sleep and reset.
module pclm_cfg_bank #(
  parameter int NREGS = 4,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && (addr == AW'(g))) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/pclk_loss_monitor.sv
module pclk_loss_monitor #(
  parameter int REF_KHZ     = 100000,
  parameter int LOSS_KHZ    = 1000,
  parameter int WIN_LEN     = 1000,
  parameter int RELOCK_LEN  = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_NREGS   = 4,
  parameter int CFG_DW      = 8,
  localparam int CFG_AW     = $clog2(CFG_NREGS)
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              sleep_en,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              clk_present,
  output logic              sleep_req,
  output logic              relock_req
);
  localparam int MIN_EDGES = (WIN_LEN * LOSS_KHZ) / REF_KHZ;

  logic [1:0] rst_sync_q;
  logic       rst_ref_n;
  logic       pix_edge, win_done, win_ok;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ref_n = rst_sync_q[1];

  pclm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .pix_clk(pix_clk), .pix_rst_n(rst_n),
    .ref_clk(ref_clk), .ref_rst_n(rst_ref_n),
    .pix_edge(pix_edge)
  );

  pclm_window #(.WIN_LEN(WIN_LEN), .MIN_EDGES(MIN_EDGES)) u_win (
    .clk(ref_clk), .rst_n(rst_ref_n), .pix_edge(pix_edge),
    .win_done(win_done), .win_ok(win_ok), .present(clk_present)
  );

  pclm_fsm #(.RELOCK_LEN(RELOCK_LEN)) u_fsm (
    .clk(ref_clk), .rst_n(rst_ref_n),
    .win_done(win_done), .win_ok(win_ok), .sleep_en(sleep_en),
    .sleep_req(sleep_req), .relock_req(relock_req)
  );

  pclm_cfg_bank #(.NREGS(CFG_NREGS), .DW(CFG_DW)) u_cfg (
    .clk(ref_clk), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata)
  );

  AST_PRESENT_ON_WINDOW: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    !$stable(clk_present) |-> $past(win_done)); // R1
  AST_LOSS_SLEEPS: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
    (!relock_req && !sleep_req && win_done && !win_ok && sleep_en) |=> (sleep_req && !clk_present)); // R2
endmodule

// File: tb/pclk_loss_monitor_tb_top.sv
`timescale 1ns/1ps
module pclk_loss_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RELOCK_LEN = 1000;
  localparam int WIN_LEN    = 1000;

  logic       ref_clk, rst_n, pix_clk, sleep_en, cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       clk_present, sleep_req, relock_req;
  logic       pix_run;
  real        pix_half;

  int n_checks = 0;
  int n_fail   = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] prev_vec;
  bit         mon_on = 0;
  time        rl_start;
  bit         done = 0;

  wire [2:0] vec = {clk_present, sleep_req, relock_req};

  pclk_loss_monitor #(.WIN_LEN(WIN_LEN), .RELOCK_LEN(RELOCK_LEN)) dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .pix_clk(pix_clk), .sleep_en(sleep_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .clk_present(clk_present),
    .sleep_req(sleep_req), .relock_req(relock_req)
  );

  initial ref_clk = 0;
  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  initial pix_clk = 0;
  always begin
    if (pix_run) #(pix_half) pix_clk = ~pix_clk;
    else #5;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Monitor: every change of the output vector pops one expected item.
  always @(negedge ref_clk) begin
    if (mon_on && rst_n) begin
      if (vec != prev_vec) begin
        if (exp_q.size() == 0) begin
          chk(0, "unexpected change", vec, prev_vec);
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(vec == e, t, vec, e);
        end
        if (vec[0] && !prev_vec[0]) rl_start = $time;
        if (!vec[0] && prev_vec[0])
          chk(($time - rl_start) == RELOCK_LEN*CLK_PERIOD, "R5 relock length",
              int'(($time - rl_start)/CLK_PERIOD), RELOCK_LEN);
      end
      prev_vec = vec;
    end
  end

  task automatic write_cfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge ref_clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge ref_clk);
    cfg_we = 0;
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge ref_clk);
      cfg_addr = 2'(i);
      #1;
      chk(cfg_rdata == 8'(8'h5A + i*8'h11), tag, cfg_rdata, 8'(8'h5A + i*8'h11));
    end
  endtask

  task automatic wait_vec(input logic [2:0] v);
    wait (vec == v);
  endtask

  task automatic wait_windows(input int n);
    repeat (n*WIN_LEN) @(negedge ref_clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(1500000 * 1ns);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired, pending items=%0d expected 0", exp_q.size());
    finish_run();
  end

  initial begin
    rst_n = 0; sleep_en = 1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    pix_half = 20.0; pix_run = 1;
    repeat (4) @(negedge ref_clk);
    rst_n = 1;
    repeat (4) @(negedge ref_clk);
    chk(vec == 3'b100, "R7 reset state", vec, 3'b100);
    prev_vec = vec; mon_on = 1;
    for (int i = 0; i < 4; i++) write_cfg(2'(i), 8'(8'h5A + i*8'h11));
    check_bank("R8 readback");
    wait_windows(3);

    // R1/R2: stop the clock while sleep is enabled
    push(3'b010, "R2 loss enters sleep");
    pix_run = 0;
    wait_vec(3'b010);
    check_bank("R8 retained in sleep");

    // R4: one good window then loss again, sleep must be kept
    push(3'b110, "R1 clock seen again");
    push(3'b010, "R4 single good window keeps sleep");
    pix_run = 1;
    wait_vec(3'b110);
    pix_run = 0;
    @(negedge ref_clk);
    wait_vec(3'b010);

    // R5: clean return through relock
    push(3'b110, "R1 clock present");
    push(3'b101, "R4 two good windows leave sleep");
    push(3'b100, "R5 relock ends active");
    pix_run = 1;
    wait_vec(3'b100);

    // R6: loss verdict coincides with relock expiry
    push(3'b010, "R2 loss enters sleep");
    push(3'b110, "R1 clock present");
    push(3'b101, "R4 leave sleep");
    push(3'b010, "R6 loss beats relock expiry");
    pix_run = 0;
    wait_vec(3'b010);
    pix_run = 1;
    wait_vec(3'b101);
    pix_run = 0;
    @(negedge ref_clk);
    wait_vec(3'b010);

    push(3'b110, "R1 clock present");
    push(3'b101, "R4 leave sleep");
    push(3'b100, "R5 relock ends active");
    pix_run = 1;
    wait_vec(3'b100);

    // R3: slow clock (0.5 MHz, 5 edges per window) with sleep disabled
    sleep_en = 0;
    push(3'b000, "R3 loss flagged without sleep");
    pix_half = 1000.0;
    wait_vec(3'b000);
    wait_windows(3);
    chk(vec == 3'b000, "R3 no sleep while disabled", vec, 3'b000);
    push(3'b100, "R1 clock restored");
    pix_half = 20.0;
    wait_vec(3'b100);
    sleep_en = 1;

    // R8: retention through reset
    check_bank("R8 retained before reset");
    @(negedge ref_clk); rst_n = 0;
    repeat (3) @(negedge ref_clk); rst_n = 1;
    repeat (4) @(negedge ref_clk);
    chk(vec == 3'b100, "R7 state after second reset", vec, 3'b100);
    check_bank("R8 retained through reset");

    wait_windows(2);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule